// File: doc/BRIEF.md
# Quad-Channel Alarm Interrupt Register Bank

This block is the byte-wide configuration and alarm register file of a four-channel line interface. A synchronous bus (address, write data, write strobe, read strobe, read data) reaches six registers. Two of them are per-channel control masks. One makes a channel loop its received data back toward the line. The other makes a channel transmit all ones. Two more are sticky alarm status registers fed by per-channel level inputs. The last two are interrupt enable masks for those status registers.

The loss-of-signal status records every change of a channel's alarm level, whether the alarm starts or ends. The driver-short status records only the start of a short. Reading a status register returns its present contents and clears the whole register at that clock edge. An alarm event that arrives in the same cycle as the clearing read is kept. A single active-high interrupt output is raised while any status bit is set and its enable bit is set.

Top module: `alarm_irq_bank`

## Requirements
- R1: After a synchronous reset, every register is zero. `loop_en`, `ones_en` and `irq` are low, and a read of every mapped address returns 00h.
- R2: A write to address 02h stores write data bits 3:0 as the loopback mask, which drives `loop_en` (bit n for channel n). A read of 02h returns the mask in bits 3:0, with bits 7:4 reading zero.
- R3: A write to address 03h stores write data bits 3:0 as the all-ones transmit mask, which drives `ones_en`. Data written to bits 7:4 is discarded, so a read of 03h returns zero in bits 7:4.
- R4: Status bit n at address 04h is set one clock after `los_in[n]` differs from its value in the previous clock. Both a rise and a fall set it. The bit stays set until it is cleared by a read.
- R5: Status bit n at address 05h is set one clock after `short_in[n]` rises. A fall of `short_in[n]` has no effect.
- R6: A read of 04h or 05h returns the value held before the clear. After that clock edge all four bits of that register are zero.
- R7: An alarm event that occurs in the same cycle as the clearing read of its status register is set in the register after that edge.
- R8: Writes to 06h and 07h store the loss-of-signal and driver-short enable masks (bit n enables channel n). `irq` is high exactly when some status bit at 04h or 05h is set together with its matching enable bit.
- R9: Writes to 04h, 05h and unmapped addresses change nothing. A read of an unmapped address returns 00h and clears nothing. `bus_rdata` is 00h while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| los_in | input | 4 | Per-channel loss-of-signal alarm level |
| short_in | input | 4 | Per-channel driver-short alarm level |
| loop_en | output | 4 | Per-channel remote loopback control |
| ones_en | output | 4 | Per-channel all-ones transmit control |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench drops a loss-of-signal alarm and checks the status bit. A latch that only caught rising edges would leave that bit clear. It lowers a driver-short input and expects no status, which catches a short latch built for any edge. It changes an alarm in the very cycle that a read clears its register. A design that gives the clear priority loses that event, and the next read returns 00h instead of the channel's bit. It also reads an unmapped address while an event is pending. A decoder that let this read clear status would lose the event, and one that wrote to reserved bits or to status addresses would read back altered contents.

// File: rtl/alm_bank_pkg.sv
package alm_bank_pkg;

    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 8;

    localparam logic [AW-1:0] ADDR_LOOP  = 8'h02;
    localparam logic [AW-1:0] ADDR_ONES  = 8'h03;
    localparam logic [AW-1:0] ADDR_LOS   = 8'h04;
    localparam logic [AW-1:0] ADDR_SHORT = 8'h05;
    localparam logic [AW-1:0] ADDR_LOSIE = 8'h06;
    localparam logic [AW-1:0] ADDR_SHIE  = 8'h07;

    // indices of the writable mask slices
    localparam int CTL_LOOP  = 0;
    localparam int CTL_ONES  = 1;
    localparam int CTL_LOSIE = 2;
    localparam int CTL_SHIE  = 3;
    localparam int NCTL      = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOOP,
        SEL_ONES,
        SEL_LOS,
        SEL_SHORT,
        SEL_LOSIE,
        SEL_SHIE
    } reg_sel_e;

    typedef struct packed {
        logic [NCH-1:0] los;
        logic [NCH-1:0] shrt;
    } alarm_vec_t;

    function automatic reg_sel_e decode_addr(input logic [AW-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_LOOP:  s = SEL_LOOP;
            ADDR_ONES:  s = SEL_ONES;
            ADDR_LOS:   s = SEL_LOS;
            ADDR_SHORT: s = SEL_SHORT;
            ADDR_LOSIE: s = SEL_LOSIE;
            ADDR_SHIE:  s = SEL_SHIE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DW-1:0] zext(input logic [NCH-1:0] v);
        return {{(DW-NCH){1'b0}}, v};
    endfunction

endpackage

// File: rtl/alm_ctrl_reg.sv
module alm_ctrl_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= d;
    end
endmodule

// File: rtl/alm_event_latch.sv
module alm_event_latch #(
    parameter int W        = 4,
    parameter bit ANY_EDGE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] status
);
    logic [W-1:0] lvl_q;
    logic [W-1:0] evt;

    generate
        if (ANY_EDGE) begin : g_change
            assign evt = lvl ^ lvl_q;
        end else begin : g_onset
            assign evt = lvl & ~lvl_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            status <= '0;
        end else begin
            lvl_q  <= lvl;
            // a new event outranks the clear so it is never dropped
            status <= (clr ? '0 : status) | evt;
        end
    end
endmodule

// File: rtl/alm_read_mux.sv
module alm_read_mux
    import alm_bank_pkg::*;
(
    input  logic           rd,
    input  reg_sel_e       sel,
    input  logic [NCH-1:0] loop_q,
    input  logic [NCH-1:0] ones_q,
    input  alarm_vec_t     st,
    input  alarm_vec_t     ie,
    output logic [DW-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_LOOP:  rdata = zext(loop_q);
                SEL_ONES:  rdata = zext(ones_q);
                SEL_LOS:   rdata = zext(st.los);
                SEL_SHORT: rdata = zext(st.shrt);
                SEL_LOSIE: rdata = zext(ie.los);
                SEL_SHIE:  rdata = zext(ie.shrt);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank
    import alm_bank_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    input  logic           bus_wr,
    input  logic           bus_rd,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] los_in,
    input  logic [NCH-1:0] short_in,
    output logic [NCH-1:0] loop_en,
    output logic [NCH-1:0] ones_en,
    output logic           irq
);
    reg_sel_e       sel;
    logic [NCTL-1:0] ctl_we;
    logic [NCH-1:0] ctl_q [NCTL];
    alarm_vec_t     st;
    alarm_vec_t     ie;
    logic [NCH-1:0] los_st;
    logic [NCH-1:0] sh_st;
    logic           unused_wdata_hi;

    assign sel             = decode_addr(bus_addr);
    assign unused_wdata_hi = ^bus_wdata[DW-1:NCH];

    always_comb begin
        ctl_we            = '0;
        ctl_we[CTL_LOOP]  = bus_wr && (sel == SEL_LOOP);
        ctl_we[CTL_ONES]  = bus_wr && (sel == SEL_ONES);
        ctl_we[CTL_LOSIE] = bus_wr && (sel == SEL_LOSIE);
        ctl_we[CTL_SHIE]  = bus_wr && (sel == SEL_SHIE);
    end

    generate
        for (genvar g = 0; g < NCTL; g++) begin : g_ctl
            alm_ctrl_reg #(.W(NCH)) u_reg (
                .clk (clk),
                .rst (rst),
                .we  (ctl_we[g]),
                .d   (bus_wdata[NCH-1:0]),
                .q   (ctl_q[g])
            );
        end
    endgenerate

    assign loop_en = ctl_q[CTL_LOOP];
    assign ones_en = ctl_q[CTL_ONES];
    assign ie.los  = ctl_q[CTL_LOSIE];
    assign ie.shrt = ctl_q[CTL_SHIE];

    alm_event_latch #(.W(NCH), .ANY_EDGE(1'b1)) u_los (
        .clk    (clk),
        .rst    (rst),
        .lvl    (los_in),
        .clr    (bus_rd && (sel == SEL_LOS)),
        .status (los_st)
    );

    alm_event_latch #(.W(NCH), .ANY_EDGE(1'b0)) u_short (
        .clk    (clk),
        .rst    (rst),
        .lvl    (short_in),
        .clr    (bus_rd && (sel == SEL_SHORT)),
        .status (sh_st)
    );

    assign st.los  = los_st;
    assign st.shrt = sh_st;

    alm_read_mux u_rmux (
        .rd     (bus_rd),
        .sel    (sel),
        .loop_q (ctl_q[CTL_LOOP]),
        .ones_q (ctl_q[CTL_ONES]),
        .st     (st),
        .ie     (ie),
        .rdata  (bus_rdata)
    );

    assign irq = |((st.los & ie.los) | (st.shrt & ie.shrt));
endmodule

// File: rtl/alarm_irq_bank_chk.sv
module alarm_irq_bank_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [3:0] los_in,
    input logic [3:0] short_in,
    input logic [3:0] los_st,
    input logic [3:0] sh_st,
    input logic [3:0] loop_en,
    input logic [3:0] ones_en,
    input logic       irq
);
    logic [3:0] los_d;
    logic [3:0] short_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            los_d   <= '0;
            short_d <= '0;
        end else begin
            los_d   <= los_in;
            short_d <= short_in;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (loop_en == 4'h0 && ones_en == 4'h0 && !irq));

    // R4
    los_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (los_in != los_d) |=> ((los_st & $past(los_in ^ los_d)) == $past(los_in ^ los_d)));

    // R5
    short_onset_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((sh_st & ~$past(sh_st)) & ~$past(short_in & ~short_d)) == 4'h0);

    // R6
    los_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h04 && los_in == los_d) |=> (los_st == 4'h0));

    // R6
    short_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h05 && (short_in & ~short_d) == 4'h0) |=> (sh_st == 4'h0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (los_st == 4'h0 && sh_st == 4'h0) |-> !irq);

    // R9
    loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == 8'h02) |=> $stable(loop_en));
endmodule

bind alarm_irq_bank alarm_irq_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .los_in   (los_in),
    .short_in (short_in),
    .los_st   (los_st),
    .sh_st    (sh_st),
    .loop_en  (loop_en),
    .ones_en  (ones_en),
    .irq      (irq)
);

// File: tb/alarm_irq_bank_tb.sv
`timescale 1ns/1ps
module alarm_irq_bank_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [3:0] los_in = '0;
    logic [3:0] short_in = '0;
    logic [3:0] loop_en;
    logic [3:0] ones_en;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    alarm_irq_bank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .los_in(los_in), .short_in(short_in), .loop_en(loop_en),
        .ones_en(ones_en), .irq(irq)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // monitor: pops expected read data in each strobe cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", bus_rdata, 8'hxx);
                end else begin
                    check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_los(input logic [3:0] v);
        @(negedge clk);
        los_in = v;
    endtask

    task automatic set_short(input logic [3:0] v);
        @(negedge clk);
        short_in = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 loop_en", {4'h0, loop_en}, 8'h00);
        check("R1 ones_en", {4'h0, ones_en}, 8'h00);
        check("R1 irq", {7'h0, irq}, 8'h00);
        for (int a = 2; a <= 7; a++) rd(a[7:0], 8'h00, "R1 reset readback");

        wr(8'h02, 8'hA5);
        #1 check("R2 loop_en", {4'h0, loop_en}, 8'h05);
        rd(8'h02, 8'h05, "R2 readback");

        wr(8'h03, 8'hFF);
        #1 check("R3 ones_en", {4'h0, ones_en}, 8'h0F);
        rd(8'h03, 8'h0F, "R3 reserved bits zero");

        set_los(4'h1);
        @(negedge clk); #1;
        check("R8 masked irq", {7'h0, irq}, 8'h00);
        rd(8'h04, 8'h01, "R4 onset");
        rd(8'h04, 8'h00, "R6 cleared");
        set_los(4'h0);
        rd(8'h04, 8'h01, "R4 recovery");

        set_short(4'h2);
        rd(8'h05, 8'h02, "R5 onset");
        set_short(4'h0);
        rd(8'h05, 8'h00, "R5 fall ignored");

        wr(8'h06, 8'h01);
        rd(8'h06, 8'h01, "R8 enable readback");
        set_los(4'h1);
        @(negedge clk); #1;
        check("R8 irq raised", {7'h0, irq}, 8'h01);
        rd(8'h04, 8'h01, "R6 value before clear");
        #1 check("R8 irq after clear", {7'h0, irq}, 8'h00);

        // R7: change bit2 in the same cycle as the clearing read
        @(negedge clk);
        bus_addr = 8'h04; bus_rd = 1'b1; los_in = 4'h5;
        exp_q.push_back(8'h00); tag_q.push_back("R7 read in event cycle");
        @(negedge clk);
        bus_rd = 1'b0;
        #1 check("R8 irq bit2 not enabled", {7'h0, irq}, 8'h00);
        rd(8'h04, 8'h04, "R7 event kept");

        wr(8'h04, 8'hFF);
        rd(8'h04, 8'h00, "R9 status write ignored");
        wr(8'h08, 8'h0F);
        #1 check("R9 unmapped write", {4'h0, loop_en}, 8'h05);
        set_los(4'h1);
        rd(8'h08, 8'h00, "R9 unmapped read");
        rd(8'h04, 8'h04, "R9 unmapped read no clear");
        #1 check("R9 idle rdata", bus_rdata, 8'h00);

        wr(8'h07, 8'h08);
        set_short(4'h8);
        @(negedge clk); #1;
        check("R8 short irq", {7'h0, irq}, 8'h01);
        rd(8'h05, 8'h08, "R5 bit3 onset");
        #1 check("R8 short irq cleared", {7'h0, irq}, 8'h00);
        set_short(4'h9);
        rd(8'h05, 8'h01, "R5 only new onset");

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) check("scoreboard leftover", 8'(exp_q.size()), 8'h00);
        summary();
        $finish;
    end
endmodule